// File: doc/BRIEF.md
# Serial Word Capture Controller

This controller turns a short serial burst into a parallel word. It sits idle until a data-valid strobe arrives. From that clock edge on it takes one serial bit per clock and writes each bit into its own position of a result register. After a fixed number of bits it raises a one-cycle completion flag. The assembled word then stays on the output, unchanged, until the first bit of the next burst overwrites it.

The control is a two-state machine with an idle state and a capture state, plus a timer that counts the bits. Whether to write a bit is decided from the current state and the present inputs (Mealy style), so the first bit is taken on the same rising edge at which the strobe is seen. The strobe, the serial bit, the machine, the timer and the result register all use that one rising edge. No bit lags the state change, and none lands one position off.

Top module: `serial_capture`

## Requirements
- R1: A synchronous active-high reset puts the machine in idle, clears the result y to all zeros and drives done low.
- R2: In idle with dv low, y keeps its value and done stays low whatever x does.
- R3: On the rising edge where dv is high in idle, x is written into y[0] and the machine enters capture.
- R4: On each of the next WIDTH-1 rising edges, serial bit k (k = 1 .. WIDTH-1, counting the bit taken with dv as bit 0) is written into y[k].
- R5: A burst takes exactly WIDTH rising edges. After the edge that writes y[WIDTH-1], the machine is back in idle and done is high.
- R6: done is high for exactly one clock cycle per burst.
- R7: dv is ignored while the machine is in capture. Holding dv high for the whole burst gives the same y and the same done timing as a one-cycle pulse.
- R8: After a burst, y holds the complete word until the next burst starts.
- R9: dv high in the cycle in which done is high starts a new burst at once, with no idle gap.
- R10: The bit timer is held at zero in idle and is reset to zero on every state change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all logic uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dv | input | 1 | Data-valid strobe that starts a burst |
| x | input | 1 | Serial data bit, one per clock |
| y | output | WIDTH | Assembled word; bit k holds serial bit k |
| done | output | 1 | One-cycle pulse when a word is complete |

## Verification
The bench runs every 4-bit word, each one once with a one-cycle dv pulse and once with dv held through the whole burst. After every edge it checks the bit just written. A design with the one-cycle lag of a state-decoded capture would lose bit 0 and shift the rest one position down, and the y[0] check would show this at once. A design that restarts on dv during capture would corrupt y or move done. Idle gaps with a toggling x catch a register that keeps sampling. Chained bursts, with dv raised in the done cycle, catch a machine that needs an extra idle cycle or that drops the first bit of the second word.

// File: rtl/serial_capture.sv
module serial_capture #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dv,
  input  logic             x,
  output logic [WIDTH-1:0] y,
  output logic             done
);
  localparam int TW = (WIDTH > 2) ? $clog2(WIDTH - 1) : 1;
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [TW-1:0] LAST = TW'(WIDTH - 2);

  typedef enum logic {ST_IDLE, ST_CAP} st_t;

  st_t           state;
  logic [TW-1:0] tmr;

  wire           start  = (state == ST_IDLE) && dv;
  wire           last   = (state == ST_CAP) && (tmr == LAST);
  wire           wr     = start || (state == ST_CAP);
  wire [IW-1:0]  wr_idx = start ? '0 : IW'(tmr) + IW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      tmr   <= '0;
      y     <= '0;
      done  <= 1'b0;
    end else begin
      if (wr) y[wr_idx] <= x;
      done <= last;
      if (start) state <= ST_CAP;
      else if (last) state <= ST_IDLE;
      if (state == ST_CAP && !last) tmr <= tmr + TW'(1);
      else tmr <= '0;
    end
  end

  assert_first_bit_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> (y[0] == $past(x)) && (state == ST_CAP));

  assert_bit_pos_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAP) |=> (y[IW'($past(tmr)) + IW'(1)] == $past(x)));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !dv) |=> ($stable(y) && state == ST_IDLE));

  assert_burst_end_R5: assert property (@(posedge clk) disable iff (rst)
    last |=> (done && state == ST_IDLE && tmr == '0));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_dv_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAP && tmr != LAST) |=> (state == ST_CAP && tmr == $past(tmr) + TW'(1)));

  assert_timer_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (tmr == '0));
endmodule

// File: tb/serial_capture_tb_top.sv
module serial_capture_tb_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dv  = 1'b0;
  logic         x   = 1'b0;
  logic [W-1:0] y;
  logic         done;
  int           n_chk = 0;
  int           n_bad = 0;

  serial_capture #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .dv(dv), .x(x), .y(y), .done(done)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge: drives bit 0 with dv high
  task automatic begin_word(input logic [W-1:0] w);
    dv = 1'b1;
    x  = w[0];
  endtask

  // drives bits 1..W-1, checking each written bit; ends at the done cycle
  task automatic body(input logic [W-1:0] w, input bit hold);
    for (int k = 1; k < W; k++) begin
      @(negedge clk);
      chk(y[k-1] == w[k-1], (k == 1) ? "R3" : "R4", y[k-1], w[k-1]);
      chk(done == 1'b0, "R6", done, 0);
      dv = hold;
      x  = w[k];
    end
    @(negedge clk);
    // R5/R10: complete after exactly W edges, done in this cycle
    chk(y == w, "R4", y, w);
    chk(done == 1'b1, "R5", done, 1);
  endtask

  task automatic idle_gap(input logic [W-1:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      dv = 1'b0;
      x  = ~x;
      @(negedge clk);
      chk(done == 1'b0, "R6", done, 0);
      chk(y == w, "R8", y, w);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(y == '0, "R1", y, 0);
    chk(done == 1'b0, "R1", done, 0);
    rst = 1'b0;
    // R2: x toggles with dv low
    for (int i = 0; i < 5; i++) begin
      x = i[0];
      @(negedge clk);
      chk(y == '0, "R2", y, 0);
      chk(done == 1'b0, "R2", done, 0);
    end
    // the 1101 stream
    begin_word(4'b1101);
    body(4'b1101, 1'b0);
    idle_gap(4'b1101, 2);
    // exhaustive sweep; hold=1 exercises R7
    for (int w = 0; w < (1 << W); w++) begin
      for (int h = 0; h < 2; h++) begin
        begin_word(W'(w));
        body(W'(w), h[0]);
        idle_gap(W'(w), 1 + (w % 3));
      end
    end
    // R9: back-to-back bursts, dv raised in the done cycle
    for (int w = 3; w < 16; w += 4) begin
      begin_word(W'(w));
      body(W'(w), 1'b0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R9", done, 0);
    chk(y == W'(15), "R9", y, 15);
    // R7: a new dv during capture must not restart or delay the burst
    begin_word(4'b0110);
    body(4'b0110, 1'b1);
    idle_gap(4'b0110, 2);
    // reset after a burst clears y
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(y == '0, "R1", y, 0);
    chk(done == 1'b0, "R1", done, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule